// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block sits between the interrupt source state of an interrupt controller and the request lines of up to eight processors. For every processor it looks at all interrupt sources together. It keeps only those that are enabled, pending, and routed to that processor. From these it picks the source with the numerically lowest priority value. It then decides whether that winner is reported to the processor and whether the processor's request line is raised.

Two thresholds act on the winner, one after the other. The processor's priority mask decides whether the winner is published as the highest pending ID. The processor's running priority decides whether the request line goes high. A source can therefore be visible as pending without interrupting the processor.

Register decoding, acknowledge and completion are handled elsewhere. Their results reach this block as plain input ports. The source count is a multiple of 32 and at most 1020. All outputs are registered once per clock.

Top module: `hpp_selector`

## Requirements
- R1: Source i is a candidate for processor c only when src_en[i], src_pend[i] and src_cpu_mask[i*NUM_CPU+c] are all 1. Among the candidates, the one with the numerically lowest 8-bit priority (src_prio[i*8+:8]) wins.
- R2: When several candidates share the lowest priority value, the one with the lowest source index wins.
- R3: When dist_en is 0, every processor reports ID 1023 and its request line is 0.
- R4: When cpu_en[c] is 0, processor c reports ID 1023 and irq_req[c] is 0. Other processors are not affected.
- R5: The winner's index appears on pend_id[c*10+:10] only when its priority is strictly below prio_mask[c*8+:8]. Otherwise the ID is 1023. An equal value does not pass.
- R6: irq_req[c] is 1 only when the winner is published (R5) and its priority is also strictly below the 9-bit running priority run_prio[c*9+:9]. The value 0x100 means idle, so any published winner raises the request.
- R7: Outputs are registered. They show the result for the inputs sampled at the previous rising clock edge and do not change between edges.
- R8: While rst_n is low, every pend_id field reads 1023 and every irq_req bit is 0.
- R9: With no candidate for a processor, its ID is 1023 and its request line is 0.
- R10: Every pend_id field is either 1023 or a source index below NUM_SRC. A source of priority 0xFF can never be published, because no 8-bit mask lies above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global distribution enable |
| cpu_en | input | NUM_CPU | Per-processor interface enable |
| src_en | input | NUM_SRC | Per-source enable |
| src_pend | input | NUM_SRC | Per-source pending |
| src_prio | input | NUM_SRC*8 | Per-source priority, source i at [i*8+:8] |
| src_cpu_mask | input | NUM_SRC*NUM_CPU | Routing, source i to processor c at bit i*NUM_CPU+c |
| prio_mask | input | NUM_CPU*8 | Per-processor priority mask |
| run_prio | input | NUM_CPU*9 | Per-processor running priority, 0x100 means idle |
| pend_id | output | NUM_CPU*10 | Per-processor highest pending ID, 1023 means none |
| irq_req | output | NUM_CPU | Per-processor request line |

## Verification
The bench targets equal priorities spread over several sources. A tree that lets the right-hand input win on a tie would report a higher index. It also drives the priority mask and the running priority to exactly the winner's priority. A design that compares with less-or-equal would publish the ID or raise the request when it must not. It clears a single routing bit, which catches a selector that ignores routing and reports the same source on every processor. It checks that only the published ID is shown while the running priority blocks the request, which catches designs that fold the two thresholds into one.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  localparam int PRIO_W = 8;
  localparam int ID_W   = 10;
  localparam int RUN_W  = PRIO_W + 1;
  localparam logic [ID_W-1:0]  NO_IRQ    = 10'd1023;
  localparam logic [RUN_W-1:0] IDLE_PRIO = 9'h100;

  typedef struct packed {
    logic [RUN_W-1:0] prio;
    logic [ID_W-1:0]  id;
  } cand_t;

  // Keep the lower-indexed side unless the upper side is strictly better.
  function automatic cand_t pick_better(cand_t lo_side, cand_t hi_side);
    return (hi_side.prio < lo_side.prio) ? hi_side : lo_side;
  endfunction

  function automatic logic beats(logic [RUN_W-1:0] p, logic [RUN_W-1:0] thr);
    return p < thr;
  endfunction
endpackage

// File: rtl/hpp_cand_tree.sv
module hpp_cand_tree
  import hpp_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int CPU_IDX = 0
) (
  input  logic [NUM_SRC-1:0]         src_en,
  input  logic [NUM_SRC-1:0]         src_pend,
  input  logic [NUM_SRC*PRIO_W-1:0]  src_prio,
  input  logic [NUM_SRC*NUM_CPU-1:0] src_cpu_mask,
  output cand_t                      best
);
  localparam int LEAVES = 1 << $clog2(NUM_SRC);
  localparam int NODES  = 2 * LEAVES - 1;

  cand_t node [NODES];

  // Leaves sit at heap positions LEAVES-1+i, so left subtrees hold lower IDs.
  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_SRC) begin : g_real
      logic hit;
      assign hit = src_en[i] & src_pend[i] & src_cpu_mask[i*NUM_CPU+CPU_IDX];
      assign node[LEAVES-1+i] = hit ?
        cand_t'{prio: {1'b0, src_prio[i*PRIO_W +: PRIO_W]}, id: ID_W'(i)} :
        cand_t'{prio: IDLE_PRIO, id: NO_IRQ};
    end else begin : g_pad
      assign node[LEAVES-1+i] = cand_t'{prio: IDLE_PRIO, id: NO_IRQ};
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    assign node[k] = pick_better(node[2*k+1], node[2*k+2]);
  end

  assign best = node[0];
endmodule

// File: rtl/hpp_cpu_gate.sv
module hpp_cpu_gate
  import hpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dist_en,
  input  logic              cpu_en,
  input  cand_t             best,
  input  logic [PRIO_W-1:0] prio_mask,
  input  logic [RUN_W-1:0]  run_prio,
  output logic              publish,
  output logic              raise,
  output logic [ID_W-1:0]   pend_id,
  output logic              irq_req
);
  logic live;

  assign live    = dist_en & cpu_en;
  assign publish = live & beats(best.prio, {1'b0, prio_mask});
  assign raise   = publish & beats(best.prio, run_prio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_id <= NO_IRQ;
      irq_req <= 1'b0;
    end else begin
      pend_id <= publish ? best.id : NO_IRQ;
      irq_req <= raise;
    end
  end
endmodule

// File: rtl/hpp_selector.sv
module hpp_selector
  import hpp_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dist_en,
  input  logic [NUM_CPU-1:0]         cpu_en,
  input  logic [NUM_SRC-1:0]         src_en,
  input  logic [NUM_SRC-1:0]         src_pend,
  input  logic [NUM_SRC*8-1:0]       src_prio,
  input  logic [NUM_SRC*NUM_CPU-1:0] src_cpu_mask,
  input  logic [NUM_CPU*8-1:0]       prio_mask,
  input  logic [NUM_CPU*9-1:0]       run_prio,
  output logic [NUM_CPU*10-1:0]      pend_id,
  output logic [NUM_CPU-1:0]         irq_req
);
  logic [NUM_CPU-1:0] cpu_publish;
  logic [NUM_CPU-1:0] cpu_raise;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    cand_t best;

    hpp_cand_tree #(
      .NUM_SRC(NUM_SRC),
      .NUM_CPU(NUM_CPU),
      .CPU_IDX(c)
    ) u_tree (
      .src_en      (src_en),
      .src_pend    (src_pend),
      .src_prio    (src_prio),
      .src_cpu_mask(src_cpu_mask),
      .best        (best)
    );

    hpp_cpu_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .dist_en  (dist_en),
      .cpu_en   (cpu_en[c]),
      .best     (best),
      .prio_mask(prio_mask[c*PRIO_W +: PRIO_W]),
      .run_prio (run_prio[c*RUN_W +: RUN_W]),
      .publish  (cpu_publish[c]),
      .raise    (cpu_raise[c]),
      .pend_id  (pend_id[c*ID_W +: ID_W]),
      .irq_req  (irq_req[c])
    );
  end
endmodule

// File: rtl/hpp_selector_chk.sv
module hpp_selector_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       dist_en,
  input logic [NUM_CPU-1:0]         cpu_en,
  input logic [NUM_SRC-1:0]         src_en,
  input logic [NUM_SRC-1:0]         src_pend,
  input logic [NUM_SRC*8-1:0]       src_prio,
  input logic [NUM_SRC*NUM_CPU-1:0] src_cpu_mask,
  input logic [NUM_CPU*8-1:0]       prio_mask,
  input logic [NUM_CPU*9-1:0]       run_prio,
  input logic [NUM_CPU*10-1:0]      pend_id,
  input logic [NUM_CPU-1:0]         irq_req
);
  logic                       past_ok;
  logic                       q_dist;
  logic [NUM_CPU-1:0]         q_cpu;
  logic [NUM_SRC-1:0]         q_en, q_pend;
  logic [NUM_SRC*8-1:0]       q_prio;
  logic [NUM_SRC*NUM_CPU-1:0] q_route;
  logic [NUM_CPU*8-1:0]       q_mask;
  logic [NUM_CPU*9-1:0]       q_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_ff @(posedge clk) begin
    q_dist  <= dist_en;
    q_cpu   <= cpu_en;
    q_en    <= src_en;
    q_pend  <= src_pend;
    q_prio  <= src_prio;
    q_route <= src_cpu_mask;
    q_mask  <= prio_mask;
    q_run   <= run_prio;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    logic [9:0] id;
    logic       any_cand;
    logic       id_cand;
    logic [7:0] id_prio;

    assign id = pend_id[c*10 +: 10];

    always_comb begin
      any_cand = 1'b0;
      id_cand  = 1'b0;
      id_prio  = 8'hFF;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (q_en[i] && q_pend[i] && q_route[i*NUM_CPU+c]) any_cand = 1'b1;
        if (32'(id) == i) begin
          id_cand = q_en[i] & q_pend[i] & q_route[i*NUM_CPU+c];
          id_prio = q_prio[i*8 +: 8];
        end
      end
    end

    AST_GLOBAL_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !q_dist |-> id == 10'd1023 && !irq_req[c]);               // R3
    AST_CPU_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !q_cpu[c] |-> id == 10'd1023 && !irq_req[c]);             // R4
    AST_ID_IS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && id != 10'd1023 |-> id_cand);                              // R1
    AST_ID_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && id != 10'd1023 |-> id_prio < q_mask[c*8 +: 8]);          // R5
    AST_REQ_NEEDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] |-> id != 10'd1023);                                      // R6
    AST_REQ_BELOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && irq_req[c] |-> {1'b0, id_prio} < q_run[c*9 +: 9]);        // R6
    AST_NONE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !any_cand |-> id == 10'd1023 && !irq_req[c]);             // R9
    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      id == 10'd1023 || 32'(id) < NUM_SRC);                                // R10
  end
endmodule

bind hpp_selector hpp_selector_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (.*);

// File: tb/tb_hpp_selector.sv
module tb_hpp_selector;
  localparam int NS = 64;
  localparam int NC = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dist_en;
  logic [NC-1:0]     cpu_en;
  logic [NS-1:0]     src_en, src_pend;
  logic [NS*8-1:0]   src_prio;
  logic [NS*NC-1:0]  src_cpu_mask;
  logic [NC*8-1:0]   prio_mask;
  logic [NC*9-1:0]   run_prio;
  logic [NC*10-1:0]  pend_id;
  logic [NC-1:0]     irq_req;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  hpp_selector #(.NUM_SRC(NS), .NUM_CPU(NC)) dut (.*);

  function automatic void model(input int c, output logic [9:0] eid, output logic eirq);
    int bp = 256;
    int bi = 1023;
    for (int i = 0; i < NS; i++)
      if (src_en[i] && src_pend[i] && src_cpu_mask[i*NC+c] && int'(src_prio[i*8 +: 8]) < bp) begin
        bp = int'(src_prio[i*8 +: 8]);
        bi = i;
      end
    eid  = 10'd1023;
    eirq = 1'b0;
    if (dist_en && cpu_en[c] && bp < int'(prio_mask[c*8 +: 8])) begin
      eid  = 10'(bi);
      eirq = bp < int'(run_prio[c*9 +: 9]);
    end
  endfunction

  task automatic compare(string tag, int c, logic [9:0] eid, logic eirq);
    vectors++;
    if (pend_id[c*10 +: 10] !== eid || irq_req[c] !== eirq) begin
      fails++;
      $display("FAIL %s cpu%0d: id=%0d irq=%0b expected id=%0d irq=%0b",
               tag, c, pend_id[c*10 +: 10], irq_req[c], eid, eirq);
    end
  endtask

  task automatic step_check(string tag);
    logic [9:0] eid;
    logic       eirq;
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      model(c, eid, eirq);
      compare(tag, c, eid, eirq);
    end
  endtask

  task automatic clear_all();
    dist_en = 1'b1;
    cpu_en = '1;
    src_en = '0;
    src_pend = '0;
    src_prio = '0;
    src_cpu_mask = '1;
    prio_mask = '1;
    for (int c = 0; c < NC; c++) run_prio[c*9 +: 9] = 9'h100;
  endtask

  task automatic raise_src(int i, logic [7:0] p);
    src_en[i] = 1'b1;
    src_pend[i] = 1'b1;
    src_prio[i*8 +: 8] = p;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [9:0] hid [NC];
    logic       hirq [NC];
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    clear_all();
    raise_src(4, 8'h10);
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) compare("R8 reset", c, 10'd1023, 1'b0);
    rst_n = 1'b1;

    step_check("R1 single source");
    raise_src(5, 8'h80);
    raise_src(10, 8'h40);
    step_check("R1 lower value wins");
    clear_all();
    raise_src(40, 8'h20);
    raise_src(7, 8'h20);
    raise_src(3, 8'h20);
    step_check("R2 tie lowest index");
    src_cpu_mask[3*NC+1] = 1'b0;
    step_check("R1 routing bit cleared");
    clear_all();
    step_check("R9 nothing pending");
    raise_src(12, 8'h30);
    src_en[12] = 1'b0;
    step_check("R1 disabled source");
    src_en[12] = 1'b1;
    dist_en = 1'b0;
    step_check("R3 global off");
    dist_en = 1'b1;
    cpu_en[1] = 1'b0;
    step_check("R4 one cpu off");
    cpu_en = '1;
    prio_mask[7:0] = 8'h30;
    step_check("R5 mask equal blocks");
    prio_mask[7:0] = 8'h31;
    step_check("R5 mask just above");
    run_prio[8:0] = 9'h030;
    step_check("R6 run equal blocks request");
    run_prio[8:0] = 9'h031;
    step_check("R6 run just above");
    clear_all();
    raise_src(NS-1, 8'hFF);
    step_check("R10 priority FF never published");

    // R7: inputs changed mid-cycle leave outputs unchanged until the next edge
    clear_all();
    raise_src(20, 8'h05);
    step_check("R7 setup");
    for (int c = 0; c < NC; c++) model(c, hid[c], hirq[c]);
    clear_all();
    raise_src(1, 8'h01);
    #1;
    for (int c = 0; c < NC; c++) compare("R7 hold until edge", c, hid[c], hirq[c]);
    step_check("R7 after edge");

    for (int n = 0; n < 3000; n++) begin
      src_en       = {$urandom, $urandom};
      src_pend     = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      src_cpu_mask = {$urandom, $urandom, $urandom, $urandom} | {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < NS; i++) src_prio[i*8 +: 8] = 8'(($urandom % 16) * 16 + ($urandom % 2));
      dist_en = ($urandom % 8) != 0;
      for (int c = 0; c < NC; c++) begin
        cpu_en[c] = ($urandom % 8) != 0;
        prio_mask[c*8 +: 8] = 8'($urandom_range(32, 255));
        run_prio[c*9 +: 9] = 9'($urandom_range(0, 256));
      end
      step_check("R1/R2/R5/R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule